// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves data words from one clock domain to another, unrelated one. Words go into a dual-port memory on the write clock and come out on the read clock. The two pointers cross the clock boundary as Gray codes through chains of flip-flops, so each flag is computed only from signals that belong to its own domain. `full` is computed in the write domain. `empty` and `almost_empty` are computed in the read domain.

A parameter selects one of two read behaviours. In standard mode the memory output register loads only when the user asserts `rd_en` while `empty` is low. In fall-through mode the block reads ahead on its own: the oldest word is placed on `rd_data` without any request, and `rd_en` acknowledges that word. Because of this read-ahead, the read counter can advance before the user reads anything. Fall-through mode also lowers `empty` one read-clock cycle later than standard mode does.

Both domains sample a single synchronous, active-high reset. The reset must stay high for several cycles of each clock.

Top module: `afifo_dc`

## Requirements
- R1: Words leave on `rd_data` in the order they were accepted on `wr_data`, and none is lost or duplicated.
- R2: In standard mode, after a write into an empty FIFO, `empty` goes low on the 3rd rising `rd_clk` edge after that write edge. It may be the 4th edge when the two clock edges fall close together.
- R3: In fall-through mode, after a write into an empty FIFO, `empty` goes low on the 4th rising `rd_clk` edge after that write edge, or on the 5th when the edges fall close. The written word is on `rd_data` from that same edge, with `rd_en` low. The word stays there until `rd_en` is sampled high.
- R4: In fall-through mode, the internal read-ahead that moves a word into the output register raises `rd_count` by one with no `rd_en`. `rd_count` stays at its old value while `empty` is still high.
- R5: In standard mode, `rd_data` resets to 0. It changes only on a `rd_clk` edge that samples `rd_en` high with `empty` low, and it shows the oldest word from that edge on.
- R6: A write sampled while `full` is high is dropped. `wr_count` does not change and the word never appears on `rd_data`.
- R7: A read sampled while `empty` is high has no effect. `rd_count` and `rd_data` do not change and `empty` stays high.
- R8: `full` rises on the write edge that brings the stored word count to capacity, once the read pointer has settled in the write domain. Capacity is 2^ADDR_W in standard mode and 2^ADDR_W+1 in fall-through mode, because the output register holds one word. `full` falls within a few write cycles after the FIFO is drained.
- R9: `almost_empty` is high exactly when the read-domain occupancy is at or below `AEMPTY_LEVEL`. In fall-through mode the occupancy includes the word in the output register. The flag updates on the read edge that changes the occupancy.
- R10: While `rst` is high, the block resets on the next edges of both clocks: `empty` and `almost_empty` go high, `full` goes low, both counters go to 0 and `rd_data` goes to 0.
- R11: `wr_count` rises by one for each accepted write. `rd_count` rises by one for each word taken out of the memory. Both count modulo 2^(ADDR_W+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock, unrelated to wr_clk |
| rst | input | 1 | Synchronous active-high reset, sampled by both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room left; writes are dropped |
| wr_count | output | ADDR_W+1 | Accepted writes, wrapping |
| rd_en | input | 1 | Read request (fall-through: acknowledge of the shown word) |
| rd_data | output | DATA_W | Registered output word |
| empty | output | 1 | No word available to the reader |
| almost_empty | output | 1 | Occupancy at or below AEMPTY_LEVEL |
| rd_count | output | ADDR_W+1 | Words taken from memory, wrapping |

## Verification
The bench builds one instance in each read mode and drives both from clocks with unrelated periods whose edges never coincide. A single write into an empty FIFO measures the `empty` latency in rising read edges. That test separates the two modes by their one-cycle difference, and it also shows whether the read-ahead moves the counter and the data without `rd_en`. A directed fill to capacity, followed by a dropped write and a paced drain, finds the capacity, the full threshold, the almost-empty threshold on every step, and any word that was dropped or misplaced. Random traffic from a seeded generator then keeps both ports busy at the same time, with the writer faster than the reader. This exercises order and stalls near full, and catches pointer-synchronisation faults that single operations cannot show.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Read behaviour of the output register.
  typedef enum logic {
    MODE_STD  = 1'b0,  // load on user request only
    MODE_FWFT = 1'b1   // read ahead, rd_en acknowledges the shown word
  } rd_mode_e;

endpackage

// File: rtl/afifo_sync.sv
// Flop chain carrying a Gray-coded pointer into another clock domain.
module afifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2   // at least 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/afifo_mem.sv
// Simple dual-port storage, written and read on separate clocks, with a
// registered read port that can reset (block RAM output register style).
module afifo_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/afifo_wr_ctl.sv
// Write-domain pointer and full flag.
module afifo_wr_ctl #(
  parameter int AW     = 4,   // at least 2
  parameter int STAGES = 2,
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_async,
  output logic          full,
  output logic          push,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray
);

  logic [PW-1:0] rgray_s;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] wgray_nx;
  logic [PW-1:0] full_pat;

  afifo_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
    .clk (clk),
    .rst (rst),
    .d   (rgray_async),
    .q   (rgray_s)
  );

  // Full: the write pointer is one lap ahead of the read pointer.
  // In Gray code that means the two top bits differ and the rest match.
  assign full_pat = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};

  assign push     = wr_en & ~full;
  assign wbin_nx  = wbin + PW'(push);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == full_pat);
    end
  end

endmodule

// File: rtl/afifo_rd_ctl.sv
// Read-domain pointer, empty and almost-empty flags, and read-ahead control.
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int       AW       = 4,
  parameter int       STAGES   = 2,
  parameter rd_mode_e RD_MODE  = MODE_STD,
  parameter int       AE_LEVEL = 2,
  localparam int      PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_async,
  output logic          empty,
  output logic          aempty,
  output logic          pop,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray
);

  localparam logic [PW-1:0] AE_LIM = PW'(AE_LEVEL);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wgray_s;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] rgray_nx;
  logic [PW-1:0] occ_nx;
  logic          mem_empty_q;
  logic          held_nx;    // word sitting in the output register next cycle

  afifo_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
    .clk (clk),
    .rst (rst),
    .d   (wgray_async),
    .q   (wgray_s)
  );

  assign wbin_s = gray_to_bin(wgray_s);

  if (RD_MODE == MODE_FWFT) begin : g_fwft
    logic shown_q;
    // Fetch whenever the output register is free or being consumed.
    assign pop     = ~mem_empty_q & (~shown_q | rd_en);
    assign held_nx = pop | (shown_q & ~rd_en);
    always_ff @(posedge clk) begin
      if (rst) shown_q <= 1'b0;
      else     shown_q <= held_nx;
    end
    assign empty = ~shown_q;
  end else begin : g_std
    assign pop     = rd_en & ~mem_empty_q;
    assign held_nx = 1'b0;
    assign empty   = mem_empty_q;
  end

  assign rbin_nx  = rbin + PW'(pop);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign occ_nx   = wbin_s - rbin_nx + PW'(held_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin        <= '0;
      rgray       <= '0;
      mem_empty_q <= 1'b1;
      aempty      <= 1'b1;
    end else begin
      rbin        <= rbin_nx;
      rgray       <= rgray_nx;
      mem_empty_q <= (rgray_nx == wgray_s);
      aempty      <= (occ_nx <= AE_LIM);
    end
  end

endmodule

// File: rtl/afifo_dc.sv
// Dual-clock FIFO, top level.
module afifo_dc
  import afifo_pkg::*;
#(
  parameter int       DATA_W       = 8,
  parameter int       ADDR_W       = 4,        // at least 2
  parameter int       SYNC_STAGES  = 2,
  parameter rd_mode_e RD_MODE      = MODE_STD,
  parameter int       AEMPTY_LEVEL = 2,
  localparam int      PW           = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic [PW-1:0]     wr_count,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic [PW-1:0]     rd_count
);

  logic          push;
  logic          pop;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;

  afifo_wr_ctl #(.AW(ADDR_W), .STAGES(SYNC_STAGES)) u_wr (
    .clk         (wr_clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rgray_async (rgray),
    .full        (full),
    .push        (push),
    .wbin        (wr_count),
    .wgray       (wgray)
  );

  afifo_rd_ctl #(
    .AW       (ADDR_W),
    .STAGES   (SYNC_STAGES),
    .RD_MODE  (RD_MODE),
    .AE_LEVEL (AEMPTY_LEVEL)
  ) u_rd (
    .clk         (rd_clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .wgray_async (wgray),
    .empty       (empty),
    .aempty      (almost_empty),
    .pop         (pop),
    .rbin        (rd_count),
    .rgray       (rgray)
  );

  afifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk  (wr_clk),
    .we    (push),
    .waddr (wr_count[ADDR_W-1:0]),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .rrst  (rst),
    .re    (pop),
    .raddr (rd_count[ADDR_W-1:0]),
    .rdata (rd_data)
  );

endmodule

// File: rtl/afifo_dc_chk.sv
module afifo_dc_chk
  import afifo_pkg::*;
#(
  parameter int       DATA_W  = 8,
  parameter int       ADDR_W  = 4,
  parameter rd_mode_e RD_MODE = MODE_STD,
  localparam int      PW      = ADDR_W + 1
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic              almost_empty,
  input logic [PW-1:0]     wr_count,
  input logic [PW-1:0]     rd_count,
  input logic [DATA_W-1:0] rd_data
);

  AST_WR_RESET: assert property (@(posedge wr_clk)
    rst |=> (!full && wr_count == '0));  // R10

  AST_RD_RESET: assert property (@(posedge rd_clk)
    rst |=> (empty && almost_empty && rd_count == '0 && rd_data == '0));  // R10

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && full) |=> $stable(wr_count));  // R6

  AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && !full) |=> (wr_count == $past(wr_count) + PW'(1)));  // R11

  AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (rst)
    1'b1 |=> (rd_count == $past(rd_count) || rd_count == $past(rd_count) + PW'(1)));  // R11

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
    (RD_MODE == MODE_STD && rd_en && empty) |=> ($stable(rd_count) && $stable(rd_data)));  // R7

  AST_STD_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    (RD_MODE == MODE_STD && !rd_en) |=> $stable(rd_data));  // R5

  AST_FWFT_HEAD_HELD: assert property (@(posedge rd_clk) disable iff (rst)
    (RD_MODE == MODE_FWFT && !empty && !rd_en) |=> (!empty && $stable(rd_data)));  // R3

  AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge rd_clk) disable iff (rst)
    (RD_MODE == MODE_STD && empty) |-> almost_empty);  // R9

endmodule

bind afifo_dc afifo_dc_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .RD_MODE (RD_MODE)
) u_afifo_dc_chk (
  .wr_clk       (wr_clk),
  .rd_clk       (rd_clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .full         (full),
  .empty        (empty),
  .almost_empty (almost_empty),
  .wr_count     (wr_count),
  .rd_count     (rd_count),
  .rd_data      (rd_data)
);

// File: tb/afifo_dc_bench.sv
`timescale 1ns/100ps
module afifo_dc_bench;
  import afifo_pkg::*;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int AEL   = 2;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst    = 1'b1;
  logic sel    = 1'b0;   // 0: standard instance, 1: fall-through instance
  logic wr_en  = 1'b0;
  logic rd_en  = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic s_full, s_empty, s_aempty, f_full, f_empty, f_aempty;
  logic [PW-1:0] s_wcnt, s_rcnt, f_wcnt, f_rcnt;
  logic [DW-1:0] s_dout, f_dout;

  logic full, empty, aempty;
  logic [PW-1:0] wcnt, rcnt;
  logic [DW-1:0] dout;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] q[$];
  bit wdone;

  // Write clock 100 MHz; read clock 13 ns, offset so edges never coincide.
  initial forever #5 wr_clk = ~wr_clk;
  initial begin
    #1.3;
    forever #6.5 rd_clk = ~rd_clk;
  end

  afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .RD_MODE(MODE_STD), .AEMPTY_LEVEL(AEL)) u_afifo_dc (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .rst (rst),
    .wr_en (wr_en & ~sel), .wr_data (wr_data), .full (s_full), .wr_count (s_wcnt),
    .rd_en (rd_en & ~sel), .rd_data (s_dout), .empty (s_empty),
    .almost_empty (s_aempty), .rd_count (s_rcnt)
  );

  afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .RD_MODE(MODE_FWFT), .AEMPTY_LEVEL(AEL)) u_afifo_dc_fwft (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .rst (rst),
    .wr_en (wr_en & sel), .wr_data (wr_data), .full (f_full), .wr_count (f_wcnt),
    .rd_en (rd_en & sel), .rd_data (f_dout), .empty (f_empty),
    .almost_empty (f_aempty), .rd_count (f_rcnt)
  );

  assign full   = sel ? f_full   : s_full;
  assign empty  = sel ? f_empty  : s_empty;
  assign aempty = sel ? f_aempty : s_aempty;
  assign wcnt   = sel ? f_wcnt   : s_wcnt;
  assign rcnt   = sel ? f_rcnt   : s_rcnt;
  assign dout   = sel ? f_dout   : s_dout;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s mode=%0d actual=%0d expected=%0d", req, sel, act, exp);
    end
  endtask

  function automatic int cap_of(input logic m);
    return m ? DEPTH + 1 : DEPTH;
  endfunction

  function automatic bit aempty_exp(input int occ);
    return occ <= AEL;
  endfunction

  task automatic do_reset();
    @(negedge wr_clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (6) @(negedge rd_clk);
    rst = 1'b0;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic reset_checks();
    chk(empty == 1'b1,  "R10 empty",        int'(empty),  1);
    chk(aempty == 1'b1, "R10 almost_empty", int'(aempty), 1);
    chk(full == 1'b0,   "R10 full",         int'(full),   0);
    chk(wcnt == '0,     "R10 wr_count",     int'(wcnt),   0);
    chk(rcnt == '0,     "R10 rd_count",     int'(rcnt),   0);
    chk(dout == '0,     "R10 rd_data",      int'(dout),   0);
  endtask

  task automatic read_pulse();
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
  endtask

  // Single write into an empty FIFO: latency, read-ahead, then empty reads.
  task automatic latency_test(input logic [DW-1:0] val);
    int nom = sel ? 4 : 3;
    int n = 0;
    @(negedge wr_clk); wr_en = 1'b1; wr_data = val;
    @(posedge wr_clk);
    fork
      begin @(negedge wr_clk); wr_en = 1'b0; end
      begin
        while (n < 20) begin
          @(posedge rd_clk); n++;
          @(negedge rd_clk);
          if (!empty) break;
          chk(rcnt == '0, "R4 count held before read-ahead", int'(rcnt), 0);
        end
      end
    join
    if (sel) begin
      chk(n == nom || n == nom + 1, "R3 empty latency", n, nom);
      chk(dout == val, "R3 word shown with empty low", int'(dout), int'(val));
      chk(rcnt == PW'(1), "R4 read-ahead counts", int'(rcnt), 1);
    end else begin
      chk(n == nom || n == nom + 1, "R2 empty latency", n, nom);
      chk(dout == '0, "R5 no data without read", int'(dout), 0);
      chk(rcnt == '0, "R11 no count without read", int'(rcnt), 0);
    end
    chk(wcnt == PW'(1), "R11 wr_count after one write", int'(wcnt), 1);
    chk(aempty == 1'b1, "R9 one word is almost empty", int'(aempty), 1);
    if (sel) begin
      repeat (3) @(negedge rd_clk);
      chk(dout == val && !empty, "R3 word held without rd_en", int'(dout), int'(val));
    end
    read_pulse();
    if (sel) begin
      chk(empty == 1'b1, "R3 acknowledge empties", int'(empty), 1);
      chk(rcnt == PW'(1), "R4 acknowledge does not recount", int'(rcnt), 1);
    end else begin
      chk(dout == val, "R5 read loads word", int'(dout), int'(val));
      chk(rcnt == PW'(1), "R11 rd_count after read", int'(rcnt), 1);
      chk(empty == 1'b1, "R2 empty after last read", int'(empty), 1);
    end
    read_pulse();
    chk(rcnt == PW'(1), "R7 empty read keeps count", int'(rcnt), 1);
    chk(empty == 1'b1, "R7 empty read keeps empty", int'(empty), 1);
    if (!sel) chk(dout == val, "R7 empty read keeps data", int'(dout), int'(val));
  endtask

  // Fill to capacity, try one extra write, then drain slowly.
  task automatic fill_drain();
    int cap = cap_of(sel);
    logic [DW-1:0] w;
    q.delete();
    @(negedge wr_clk); wr_en = 1'b1; w = 8'h10; wr_data = w; q.push_back(w);
    @(negedge wr_clk); wr_en = 1'b0;
    repeat (12) @(negedge rd_clk);
    for (int i = 1; i < cap; i++) begin
      @(negedge wr_clk);
      chk(full == 1'b0, "R8 full low below capacity", int'(full), 0);
      w = DW'($urandom); wr_en = 1'b1; wr_data = w; q.push_back(w);
    end
    @(negedge wr_clk); wr_en = 1'b0;
    chk(full == 1'b1, "R8 full at capacity", int'(full), 1);
    chk(wcnt == PW'(cap), "R11 wr_count at capacity", int'(wcnt), cap);
    @(negedge wr_clk); wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge wr_clk); wr_en = 1'b0;
    chk(wcnt == PW'(cap), "R6 write while full dropped", int'(wcnt), cap);
    chk(full == 1'b1, "R6 still full", int'(full), 1);
    repeat (12) @(negedge rd_clk);
    chk(aempty == 1'b0, "R9 high occupancy", int'(aempty), 0);
    for (int i = 0; i < cap; i++) begin
      w = q.pop_front();
      if (sel) begin
        @(negedge rd_clk);
        chk(!empty && dout == w, "R1 fall-through order", int'(dout), int'(w));
        rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
      end else begin
        read_pulse();
        chk(dout == w, "R1 standard order", int'(dout), int'(w));
      end
      chk(aempty == aempty_exp(cap - 1 - i), "R9 almost_empty threshold",
          int'(aempty), int'(aempty_exp(cap - 1 - i)));
    end
    repeat (2) @(negedge rd_clk);
    chk(empty == 1'b1, "R6 dropped word absent", int'(empty), 1);
    chk(rcnt == PW'(cap), "R11 rd_count after drain", int'(rcnt), cap);
    repeat (6) @(negedge wr_clk);
    chk(full == 1'b0, "R8 full clears after drain", int'(full), 0);
  endtask

  // Seeded random traffic on both ports at once.
  task automatic random_traffic();
    logic [DW-1:0] expd = '0;
    bit pend = 0;
    q.delete();
    wdone = 0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          @(negedge wr_clk);
          wr_en = ($urandom % 100) < 60;
          wr_data = DW'($urandom);
          if (wr_en && !full) q.push_back(wr_data);
        end
        @(negedge wr_clk); wr_en = 1'b0;
        wdone = 1;
      end
      begin
        forever begin
          @(negedge rd_clk);
          if (pend) begin
            chk(dout == expd, "R1 random order", int'(dout), int'(expd));
            pend = 0;
          end
          if (wdone && q.size() == 0) break;
          rd_en = wdone ? 1'b1 : (($urandom % 100) < 45);
          if (rd_en && !empty) begin
            if (q.size() == 0) begin
              chk(1'b0, "R1 word from nowhere", 1, 0);
            end else if (sel) begin
              expd = q.pop_front();
              chk(dout == expd, "R1 random order", int'(dout), int'(expd));
            end else begin
              expd = q.pop_front();
              pend = 1;
            end
          end
        end
        rd_en = 1'b0;
      end
    join
    repeat (4) @(negedge rd_clk);
    chk(empty == 1'b1, "R1 empty after random run", int'(empty), 1);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) begin
      sel = m[0];
      do_reset();
      reset_checks();
      latency_test(8'hA5);
      do_reset();
      reset_checks();
      fill_drain();
      do_reset();
      random_traffic();
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule